// File: doc/BRIEF.md
# Instruction Prefix Extension Unit

This unit sits next to the instruction decoder of a processor whose instructions are all 16 bits wide and each complete in one clock. Some instructions cannot carry everything they need. A 16-bit immediate does not fit, and register indices above the range of the instruction's short index fields cannot be encoded. For these cases the program places a prefix instruction directly in front of the consuming instruction. The prefix carries one byte. The unit captures that byte and applies it to the very next executed instruction only, so a prefixed operation costs two cycles in total.

On the consuming instruction the same byte serves three purposes at once. It becomes the high byte of the 16-bit operand, whose low byte comes from the instruction's immediate field. Its upper nibble extends the destination index. Its lower nibble extends the source index. A separate valid flag is kept beside the captured byte. It records whether a prefix was written at all, and that flag alone decides whether a branch target is absolute or relative. A prefix of 00h therefore still makes a branch absolute.

The unit obeys a pipeline enable. While the enable is low, the captured prefix and its valid flag are held until the consuming instruction really executes.

Top module: `pfx_ext_unit`

## Requirements
- R1: A synchronous active-high reset clears the prefix. In the following cycle the operand high byte is 00h, both index extensions are zero, and a branch is reported as relative.
- R2: When `pfx_wr` is high in a cycle where `en` is high, the next cycle's `operand` equals {captured byte, `imm_lo`}.
- R3: Without a live prefix, `operand` equals {8'h00, `imm_lo`}.
- R4: A prefix is live for exactly one executed cycle. After a cycle with `en` high and `pfx_wr` low, the prefix is gone: the high byte is 00h, the index extensions are zero and a branch is relative.
- R5: `br_abs` equals `is_branch` AND (prefix live), and `br_rel` equals `is_branch` AND NOT (prefix live). This holds for any prefix value, including 00h. When `is_branch` is low, both outputs are low.
- R6: `dst_idx` is {prefix bits [7:4], `dst_lo`[2:0]}, with the upper 4 bits zero when no prefix is live.
- R7: `src_idx` is {prefix bits [3:0], `src_lo`[3:0]}, with the upper 4 bits zero when no prefix is live.
- R8: A single prefix supplies the operand high byte, the destination extension and the source extension to the same instruction in the same cycle.
- R9: While `en` is low, the live prefix and its valid flag are held unchanged, and `pfx_wr` is ignored. The prefix is consumed only by the first cycle with `en` high.
- R10: Two executed prefix writes in a row: the second byte replaces the first, and only the latest byte applies to the next non-prefix instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Pipeline advance; low means the current instruction is stalled |
| pfx_wr | input | 1 | Decoded prefix instruction strobe |
| pfx_data | input | 8 | Byte carried by the prefix instruction |
| imm_lo | input | 8 | Immediate field of the current instruction |
| src_lo | input | 4 | Short source index field |
| dst_lo | input | 3 | Short destination index field |
| is_branch | input | 1 | Current instruction is a branch |
| operand | output | 16 | Extended immediate operand |
| src_idx | output | 8 | Extended source register index |
| dst_idx | output | 7 | Extended destination register index |
| br_abs | output | 1 | Branch target is absolute |
| br_rel | output | 1 | Branch target is relative |

## Verification
A wrong valid flag shows up in the first cycle after the prefix should have been captured or dropped. It appears on `br_abs`/`br_rel` whenever a branch is presented. A zero prefix byte exposes it most clearly, because a flag that is only inferred from the data would wrongly report the branch as relative. A corrupted or stale captured byte appears on the operand's high byte and on the upper index bits in that same cycle. A prefix that outlives its single executed cycle, or that is dropped during a stall, differs from the reference model one clock later. The bench therefore compares every output on every clock, across stalls, back-to-back prefixes and zero-valued prefixes.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

    // Prefix byte width and instruction field widths
    localparam int PFX_W     = 8;
    localparam int IMM_LO_W  = 8;
    localparam int OPND_W    = PFX_W + IMM_LO_W;
    localparam int DST_LO_W  = 3;
    localparam int SRC_LO_W  = 4;

    // Fixed split of the prefix byte: upper part extends the destination,
    // lower part extends the source.
    localparam int DST_EXT_W = 4;
    localparam int SRC_EXT_W = PFX_W - DST_EXT_W;
    localparam int DST_IDX_W = DST_EXT_W + DST_LO_W;
    localparam int SRC_IDX_W = SRC_EXT_W + SRC_LO_W;

    typedef logic [PFX_W-1:0]     pfx_byte_t;
    typedef logic [OPND_W-1:0]    opnd_t;
    typedef logic [DST_EXT_W-1:0] dst_ext_t;
    typedef logic [SRC_EXT_W-1:0] src_ext_t;

    // Captured prefix: data plus an independent liveness flag
    typedef struct packed {
        logic      live;
        pfx_byte_t data;
    } pfx_state_t;

    localparam pfx_state_t PFX_IDLE = '{live: 1'b0, data: '0};

    // Branch target interpretation
    typedef enum logic [1:0] {
        BR_NONE = 2'b00,
        BR_REL  = 2'b01,
        BR_ABS  = 2'b10
    } br_kind_e;

    function automatic dst_ext_t dst_ext_of(input pfx_state_t s);
        return s.live ? s.data[PFX_W-1 -: DST_EXT_W] : '0;
    endfunction

    function automatic src_ext_t src_ext_of(input pfx_state_t s);
        return s.live ? s.data[SRC_EXT_W-1:0] : '0;
    endfunction

    function automatic pfx_byte_t high_byte_of(input pfx_state_t s);
        return s.live ? s.data : '0;
    endfunction

    function automatic br_kind_e classify_branch(input logic is_br, input logic live);
        if (!is_br)
            return BR_NONE;
        return live ? BR_ABS : BR_REL;
    endfunction

endpackage

// File: rtl/pfx_state_reg.sv
module pfx_state_reg
    import pfx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       pfx_wr,
    input  pfx_byte_t  pfx_data,
    output pfx_state_t state
);

    pfx_state_t state_q;
    pfx_state_t state_d;

    always_comb begin
        state_d = state_q;
        if (en) begin
            if (pfx_wr) begin
                state_d.live = 1'b1;
                state_d.data = pfx_data;
            end else begin
                state_d = PFX_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= PFX_IDLE;
        else
            state_q <= state_d;
    end

    assign state = state_q;

endmodule

// File: rtl/pfx_operand_mux.sv
module pfx_operand_mux
    import pfx_pkg::*;
(
    input  pfx_state_t          state,
    input  logic [IMM_LO_W-1:0] imm_lo,
    output opnd_t               operand
);

    pfx_byte_t hi;

    always_comb begin
        hi      = high_byte_of(state);
        operand = {hi, imm_lo};
    end

endmodule

// File: rtl/pfx_index_ext.sv
module pfx_index_ext #(
    parameter int LO_W  = 4,
    parameter int EXT_W = 4
) (
    input  logic [EXT_W-1:0]      ext_bits,
    input  logic [LO_W-1:0]       lo,
    output logic [EXT_W+LO_W-1:0] idx
);

    localparam int IDX_W = EXT_W + LO_W;

    logic [IDX_W-1:0] joined;

    always_comb begin
        joined = '0;
        joined[LO_W-1:0]     = lo;
        joined[IDX_W-1:LO_W] = ext_bits;
    end

    assign idx = joined;

endmodule

// File: rtl/pfx_branch_sel.sv
module pfx_branch_sel
    import pfx_pkg::*;
(
    input  logic is_branch,
    input  logic live,
    output logic br_abs,
    output logic br_rel
);

    br_kind_e kind;

    always_comb begin
        kind   = classify_branch(is_branch, live);
        br_abs = (kind == BR_ABS);
        br_rel = (kind == BR_REL);
    end

endmodule

// File: rtl/pfx_ext_unit.sv
module pfx_ext_unit
    import pfx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 pfx_wr,
    input  logic [PFX_W-1:0]     pfx_data,
    input  logic [IMM_LO_W-1:0]  imm_lo,
    input  logic [SRC_LO_W-1:0]  src_lo,
    input  logic [DST_LO_W-1:0]  dst_lo,
    input  logic                 is_branch,
    output logic [OPND_W-1:0]    operand,
    output logic [SRC_IDX_W-1:0] src_idx,
    output logic [DST_IDX_W-1:0] dst_idx,
    output logic                 br_abs,
    output logic                 br_rel
);

    pfx_state_t cur;
    dst_ext_t   dst_ext;
    src_ext_t   src_ext;

    pfx_state_reg u_state (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .pfx_wr   (pfx_wr),
        .pfx_data (pfx_data),
        .state    (cur)
    );

    pfx_operand_mux u_opnd (
        .state   (cur),
        .imm_lo  (imm_lo),
        .operand (operand)
    );

    assign dst_ext = dst_ext_of(cur);
    assign src_ext = src_ext_of(cur);

    pfx_index_ext #(.LO_W(DST_LO_W), .EXT_W(DST_EXT_W)) u_dst_ext (
        .ext_bits (dst_ext),
        .lo       (dst_lo),
        .idx      (dst_idx)
    );

    pfx_index_ext #(.LO_W(SRC_LO_W), .EXT_W(SRC_EXT_W)) u_src_ext (
        .ext_bits (src_ext),
        .lo       (src_lo),
        .idx      (src_idx)
    );

    pfx_branch_sel u_br (
        .is_branch (is_branch),
        .live      (cur.live),
        .br_abs    (br_abs),
        .br_rel    (br_rel)
    );

endmodule

// File: rtl/pfx_ext_unit_chk.sv
module pfx_ext_unit_chk
    import pfx_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 en,
    input logic                 pfx_wr,
    input logic [PFX_W-1:0]     pfx_data,
    input logic [IMM_LO_W-1:0]  imm_lo,
    input logic [SRC_LO_W-1:0]  src_lo,
    input logic [DST_LO_W-1:0]  dst_lo,
    input logic                 is_branch,
    input logic [OPND_W-1:0]    operand,
    input logic [SRC_IDX_W-1:0] src_idx,
    input logic [DST_IDX_W-1:0] dst_idx,
    input logic                 br_abs,
    input logic                 br_rel
);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (operand[OPND_W-1:IMM_LO_W] == '0 && !br_abs));

    // R2
    capture_high_chk: assert property (@(posedge clk) disable iff (rst)
        (en && pfx_wr) |=> (operand[OPND_W-1:IMM_LO_W] == $past(pfx_data)));

    // R4
    one_cycle_life_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !pfx_wr) |=> (operand[OPND_W-1:IMM_LO_W] == '0 && !br_abs
                             && dst_idx[DST_IDX_W-1:DST_LO_W] == '0
                             && src_idx[SRC_IDX_W-1:SRC_LO_W] == '0));

    // R5
    branch_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({br_abs, br_rel}) && ((br_abs || br_rel) == is_branch));

    // R5
    zero_prefix_abs_chk: assert property (@(posedge clk) disable iff (rst)
        (en && pfx_wr) |=> (!is_branch || br_abs));

    // R6
    dst_low_pass_chk: assert property (@(posedge clk) disable iff (rst)
        dst_idx[DST_LO_W-1:0] == dst_lo);

    // R7
    src_low_pass_chk: assert property (@(posedge clk) disable iff (rst)
        src_idx[SRC_LO_W-1:0] == src_lo);

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!en && !$past(rst)) |=> ($stable(operand[OPND_W-1:IMM_LO_W])
                                  && $stable(dst_idx[DST_IDX_W-1:DST_LO_W])
                                  && $stable(src_idx[SRC_IDX_W-1:SRC_LO_W])));

endmodule

bind pfx_ext_unit pfx_ext_unit_chk u_chk (.*);

// File: tb/pfx_ext_unit_tb.sv
module pfx_ext_unit_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        en;
    logic        pfx_wr;
    logic [7:0]  pfx_data;
    logic [7:0]  imm_lo;
    logic [3:0]  src_lo;
    logic [2:0]  dst_lo;
    logic        is_branch;
    logic [15:0] operand;
    logic [7:0]  src_idx;
    logic [6:0]  dst_idx;
    logic        br_abs;
    logic        br_rel;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // reference state
    bit ref_live = 0;
    int ref_data = 0;

    always #10 clk = ~clk;

    pfx_ext_unit u_dut (
        .clk(clk), .rst(rst), .en(en), .pfx_wr(pfx_wr), .pfx_data(pfx_data),
        .imm_lo(imm_lo), .src_lo(src_lo), .dst_lo(dst_lo), .is_branch(is_branch),
        .operand(operand), .src_idx(src_idx), .dst_idx(dst_idx),
        .br_abs(br_abs), .br_rel(br_rel)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // compare all outputs against the reference model
    task automatic compare(input string scen);
        int hi;
        hi = ref_live ? ref_data : 0;
        chk({scen, " R2/R3 operand"}, operand, hi * 256 + imm_lo);
        chk({scen, " R6 dst_idx"}, dst_idx, (hi / 16) * 8 + dst_lo);
        chk({scen, " R7 src_idx"}, src_idx, (hi % 16) * 16 + src_lo);
        chk({scen, " R5 br_abs"}, br_abs, (is_branch && ref_live) ? 1 : 0);
        chk({scen, " R5 br_rel"}, br_rel, (is_branch && !ref_live) ? 1 : 0);
    endtask

    // one clock: drive at negedge, compare, then advance the model
    task automatic step(input string scen, input bit e, input bit w, input int d,
                        input bit br);
        @(negedge clk);
        en        = e;
        pfx_wr    = w;
        pfx_data  = d[7:0];
        imm_lo    = 8'($urandom);
        src_lo    = 4'($urandom);
        dst_lo    = 3'($urandom);
        is_branch = br;
        #2;
        compare(scen);
        @(posedge clk);
        #1;
        if (rst) begin
            ref_live = 0; ref_data = 0;
        end else if (e) begin
            if (w) begin ref_live = 1; ref_data = d; end
            else begin ref_live = 0; ref_data = 0; end
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1; en = 1; pfx_wr = 1; pfx_data = 8'hA5;
        imm_lo = 0; src_lo = 0; dst_lo = 0; is_branch = 1;
        repeat (2) @(posedge clk);
        #1;
        // R1: reset held with a prefix write pending
        step("R1 reset", 1, 1, 8'h5A, 1);
        rst = 0;
        step("R1 after reset", 1, 0, 0, 1);

        // R3: no prefix
        step("R3 plain", 1, 0, 0, 0);
        step("R3 plain br", 1, 0, 0, 1);

        // R2 R8: prefix then consumer using all fields
        step("R2 prefix", 1, 1, 8'hC3, 0);
        step("R8 consume", 1, 0, 0, 1);
        // R4: gone after one executed cycle
        step("R4 expired", 1, 0, 0, 1);

        // R5: zero-valued prefix still makes branch absolute
        step("R5 zero pfx", 1, 1, 8'h00, 0);
        step("R5 zero abs", 1, 0, 0, 1);
        step("R5 after", 1, 0, 0, 1);

        // R10: back-to-back prefixes
        step("R10 first", 1, 1, 8'h12, 0);
        step("R10 second", 1, 1, 8'hF7, 0);
        step("R10 consume", 1, 0, 0, 1);
        step("R10 after", 1, 0, 0, 0);

        // R9: stall holds the prefix and ignores writes while stalled
        step("R9 prefix", 1, 1, 8'h9E, 0);
        step("R9 stall1", 0, 1, 8'h33, 1);
        step("R9 stall2", 0, 0, 0, 1);
        step("R9 consume", 1, 0, 0, 1);
        step("R9 after", 1, 0, 0, 1);
        // R9: stall with no prefix live; write during stall ignored
        step("R9 idle stall", 0, 1, 8'h44, 1);
        step("R9 idle after", 1, 0, 0, 1);

        // R6 R7: mixed random traffic
        for (int i = 0; i < 300; i++) begin
            step("R6/R7 random", ($urandom % 4) != 0, ($urandom % 3) == 0,
                 int'($urandom % 256), ($urandom % 2) == 1);
        end

        // R1: reset in the middle of a live prefix
        step("R1 pre", 1, 1, 8'hEE, 0);
        rst = 1;
        step("R1 mid", 1, 0, 0, 1);
        rst = 0;
        step("R1 mid after", 1, 0, 0, 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule